// File: doc/BRIEF.md
# Packed Double-to-Int32 Truncating Converter

This block turns up to four IEEE-754 double-precision values into signed 32-bit integers. Each value is rounded toward zero. A 256-bit source vector carries the doubles. Lane i of the source sits in bits [64i+63:64i], and its integer result is placed in destination bits [32i+31:32i].

A two-bit mode picks how many lanes are converted and what happens to the upper destination bits. In one two-lane mode the previous destination upper half is merged back in. The other two-lane mode and the four-lane mode zero the unused bits. The caller supplies:
- the previous destination value, and
- the invalid-exception mask.

The block returns:
- the new destination,
- sticky-style invalid and precision flags for the operation,
- a fault when an invalid result is not masked, and
- an undefined-opcode fault when a 4-bit reserved operand field holds a value that is not allowed.

The datapath is combinational. A single register stage sits on its output, so the result appears one cycle after a valid request.

Top module: `fp64_trunc_cvt`

## Requirements
- R1: For an in-range lane, the result is the source value truncated toward zero (fraction discarded), as a two's-complement 32-bit integer.
- R2: A lane is invalid when it is NaN or ±infinity, or when its truncated value exceeds 2147483647 or is below -2147483648. With `inv_mask_i`=1, an invalid lane yields 32'h80000000 and `inv_o`=1.
- R3: A value of exactly -2^31, or a negative value above -2^31-1 that truncates to -2^31, is valid. It yields 32'h80000000 and does not raise `inv_o`.
- R4: Zeros and subnormals yield 0. `prec_o` is the OR over active, valid lanes of "the value had a nonzero fraction", so a nonzero subnormal raises it and ±0 does not. An invalid lane never raises precision.
- R5: Mode encoding:
  - `mode_i`=0 is the two-lane merge mode.
  - `mode_i`=1 is the two-lane zeroing mode.
  - `mode_i`=2 is the four-lane zeroing mode.

  Two-lane modes convert lanes 0–1 only. Lanes 2–3 then affect neither the destination nor the flags.
- R6: In mode 0, `dst_o`[127:64] is zero and `dst_o`[255:128] equals `old_dst_i`[255:128].
- R7: In mode 1, `dst_o`[255:64] is zero.
- R8: In mode 2, `dst_o`[255:128] is zero.
- R9: `fault_ud_o` is raised in two cases:
  - in modes 1 and 2 when `rsvd_i` ≠ 4'b1111;
  - always for `mode_i`=3.

  `rsvd_i` is ignored in mode 0. On this fault, `dst_o` equals `old_dst_i`, `inv_o`=`prec_o`=0 and `fault_inv_o`=0.
- R10: When an active lane is invalid and `inv_mask_i`=0 (with no undefined-opcode fault), `fault_inv_o`=1, `inv_o`=1 and `dst_o` equals `old_dst_i`.
- R11: Outputs are registered. `valid_o` follows `valid_i` by one cycle, and the other outputs change only on a valid request. After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| mode_i | input | 2 | Lane count / upper-bit handling mode |
| rsvd_i | input | 4 | Reserved operand field, must be 4'b1111 in zeroing modes |
| inv_mask_i | input | 1 | 1 = invalid exception masked |
| src_i | input | 256 | Four packed doubles |
| old_dst_i | input | 256 | Previous destination value |
| valid_o | output | 1 | Result strobe |
| dst_o | output | 256 | New destination value |
| inv_o | output | 1 | Invalid flag |
| prec_o | output | 1 | Precision (inexact) flag |
| fault_inv_o | output | 1 | Unmasked invalid fault |
| fault_ud_o | output | 1 | Undefined-opcode fault |

## Verification
The assertions compare each registered result with the inputs captured one edge earlier. They therefore assume that `mode_i` and `old_dst_i` are only meaningful in the cycle `valid_i` is high. They also assume that `valid_i` is low while reset is asserted.

The stimulus meets these conditions:
- All inputs are driven away from the clock edge.
- `valid_i` is held low through reset.
- Every request lasts exactly one cycle, with an idle cycle after it.

Random lanes are biased toward exponent values near the 2^31 boundary, the special exponents and subnormals. This keeps the invalid, precision and -2^31 corner paths busy alongside ordinary values.

// File: rtl/fp2i_pkg.sv
package fp2i_pkg;
  localparam int unsigned LANE_IN_W  = 64;
  localparam int unsigned LANE_OUT_W = 32;
  localparam int unsigned EXP_W      = 11;
  localparam int unsigned MAN_W      = 52;
  localparam int unsigned RSVD_W     = 4;

  localparam logic [EXP_W-1:0]      EXP_BIAS = 11'd1023;
  localparam logic [EXP_W-1:0]      EXP_SPEC = '1;
  localparam logic [LANE_OUT_W-1:0] INDEF    = 32'h8000_0000;
  localparam logic [RSVD_W-1:0]     RSVD_OK  = '1;

  typedef enum logic [1:0] {
    CVT_MERGE2 = 2'd0,
    CVT_ZERO2  = 2'd1,
    CVT_ZERO4  = 2'd2,
    CVT_BAD    = 2'd3
  } cvt_mode_e;

  typedef struct packed {
    logic [LANE_OUT_W-1:0] val;
    logic                  inv;
    logic                  inx;
  } lane_res_t;
endpackage

// File: rtl/fp2i_lane.sv
module fp2i_lane
  import fp2i_pkg::*;
(
  input  logic [LANE_IN_W-1:0] op_i,
  output lane_res_t            res_o
);
  localparam logic [EXP_W-1:0] EXP_TOP = EXP_BIAS + 11'd31;
  localparam logic [EXP_W-1:0] EXP_ONE = EXP_BIAS + 11'(MAN_W);

  logic                  sgn;
  logic [EXP_W-1:0]      ex;
  logic [MAN_W-1:0]      man;
  logic [MAN_W:0]        sig;
  logic [EXP_W-1:0]      sh_w;
  logic [5:0]            sh;
  logic [LANE_OUT_W-1:0] mag;

  always_comb begin
    sgn  = op_i[LANE_IN_W-1];
    ex   = op_i[LANE_IN_W-2 -: EXP_W];
    man  = op_i[MAN_W-1:0];
    sig  = {1'b1, man};
    sh_w = EXP_ONE - ex;
    sh   = sh_w[5:0];
    mag  = '0;
    res_o = '0;
    if (ex == EXP_SPEC) begin
      res_o.inv = 1'b1;
    end else if (ex < EXP_BIAS) begin
      // |x| < 1: result 0, inexact unless exactly zero
      res_o.inx = (ex != '0) || (man != '0);
    end else if (ex > EXP_TOP) begin
      res_o.inv = 1'b1;
    end else begin
      // exponent 0..31: shift 52..21
      mag       = LANE_OUT_W'(sig >> sh);
      res_o.inx = |(sig & (({{MAN_W{1'b0}}, 1'b1} << sh) - 1'b1));
      if (mag[LANE_OUT_W-1] && !(sgn && mag == INDEF)) res_o.inv = 1'b1;
      else res_o.val = sgn ? (~mag + 1'b1) : mag;
    end
    if (res_o.inv) begin
      res_o.val = INDEF;
      res_o.inx = 1'b0;
    end
  end
endmodule

// File: rtl/fp2i_mode_dec.sv
module fp2i_mode_dec
  import fp2i_pkg::*;
#(
  parameter int unsigned N_LANES = 4
) (
  input  logic [1:0]         mode_i,
  input  logic [RSVD_W-1:0]  rsvd_i,
  output logic [N_LANES-1:0] lane_en_o,
  output logic               keep_upper_o,
  output logic               ud_o
);
  localparam int unsigned HALF = N_LANES / 2;

  always_comb begin
    lane_en_o    = '0;
    keep_upper_o = 1'b0;
    ud_o         = 1'b0;
    case (cvt_mode_e'(mode_i))
      CVT_MERGE2: begin
        lane_en_o[HALF-1:0] = '1;
        keep_upper_o        = 1'b1;
      end
      CVT_ZERO2: begin
        lane_en_o[HALF-1:0] = '1;
        ud_o                = (rsvd_i != RSVD_OK);
      end
      CVT_ZERO4: begin
        lane_en_o = '1;
        ud_o      = (rsvd_i != RSVD_OK);
      end
      default: ud_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/fp2i_pack.sv
module fp2i_pack
  import fp2i_pkg::*;
#(
  parameter int unsigned N_LANES = 4,
  parameter int unsigned DST_W   = 256,
  localparam int unsigned HALF_W = DST_W / 2
) (
  input  logic [N_LANES-1:0][LANE_OUT_W-1:0] lane_val_i,
  input  logic [N_LANES-1:0]                 lane_en_i,
  input  logic                               keep_upper_i,
  input  logic [DST_W-HALF_W-1:0]            old_upper_i,
  output logic [DST_W-1:0]                   dst_o
);
  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign dst_o[g*LANE_OUT_W +: LANE_OUT_W] = lane_en_i[g] ? lane_val_i[g] : '0;
  end
  if (N_LANES * LANE_OUT_W < HALF_W) begin : g_pad
    assign dst_o[HALF_W-1:N_LANES*LANE_OUT_W] = '0;
  end
  assign dst_o[DST_W-1:HALF_W] = keep_upper_i ? old_upper_i : '0;
endmodule

// File: rtl/fp64_trunc_cvt.sv
module fp64_trunc_cvt
  import fp2i_pkg::*;
#(
  parameter int unsigned N_LANES = 4,
  localparam int unsigned SRC_W  = N_LANES * LANE_IN_W,
  localparam int unsigned DST_W  = SRC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [RSVD_W-1:0] rsvd_i,
  input  logic              inv_mask_i,
  input  logic [SRC_W-1:0]  src_i,
  input  logic [DST_W-1:0]  old_dst_i,
  output logic              valid_o,
  output logic [DST_W-1:0]  dst_o,
  output logic              inv_o,
  output logic              prec_o,
  output logic              fault_inv_o,
  output logic              fault_ud_o
);
  localparam int unsigned HALF_W = DST_W / 2;
  localparam int unsigned PAIR_W = 2 * LANE_OUT_W;

  lane_res_t [N_LANES-1:0]                 lane_res;
  logic      [N_LANES-1:0][LANE_OUT_W-1:0] lane_val;
  logic      [N_LANES-1:0]                 lane_en;
  logic                                    keep_upper, ud;
  logic      [DST_W-1:0]                   packed_dst, nxt_dst;
  logic                                    inv_any, inx_any, inv_trap;

  for (genvar g = 0; g < N_LANES; g++) begin : g_cvt
    fp2i_lane u_lane (
      .op_i  (src_i[g*LANE_IN_W +: LANE_IN_W]),
      .res_o (lane_res[g])
    );
    assign lane_val[g] = lane_res[g].val;
  end

  fp2i_mode_dec #(.N_LANES(N_LANES)) u_dec (
    .mode_i       (mode_i),
    .rsvd_i       (rsvd_i),
    .lane_en_o    (lane_en),
    .keep_upper_o (keep_upper),
    .ud_o         (ud)
  );

  fp2i_pack #(.N_LANES(N_LANES), .DST_W(DST_W)) u_pack (
    .lane_val_i   (lane_val),
    .lane_en_i    (lane_en),
    .keep_upper_i (keep_upper),
    .old_upper_i  (old_dst_i[DST_W-1:HALF_W]),
    .dst_o        (packed_dst)
  );

  always_comb begin
    inv_any = 1'b0;
    inx_any = 1'b0;
    for (int i = 0; i < N_LANES; i++) begin
      if (lane_en[i]) begin
        inv_any |= lane_res[i].inv;
        inx_any |= lane_res[i].inx;
      end
    end
    inv_trap = !ud && inv_any && !inv_mask_i;
    nxt_dst  = (ud || inv_trap) ? old_dst_i : packed_dst;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      dst_o       <= '0;
      inv_o       <= 1'b0;
      prec_o      <= 1'b0;
      fault_inv_o <= 1'b0;
      fault_ud_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dst_o       <= nxt_dst;
        inv_o       <= !ud && inv_any;
        prec_o      <= !ud && inx_any;
        fault_inv_o <= inv_trap;
        fault_ud_o  <= ud;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i)); // R11
  AST_UD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && fault_ud_o |-> dst_o == $past(old_dst_i) && !inv_o && !prec_o && !fault_inv_o); // R9
  AST_INV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && fault_inv_o |-> dst_o == $past(old_dst_i) && inv_o); // R10
  AST_MERGE_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !fault_ud_o && !fault_inv_o && $past(mode_i) == 2'd0 |->
      dst_o[DST_W-1:HALF_W] == $past(old_dst_i[DST_W-1:HALF_W]) &&
      dst_o[HALF_W-1:PAIR_W] == '0); // R6
  AST_ZERO2_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !fault_ud_o && !fault_inv_o && $past(mode_i) == 2'd1 |->
      dst_o[DST_W-1:PAIR_W] == '0); // R7
  AST_ZERO4_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !fault_ud_o && !fault_inv_o && $past(mode_i) == 2'd2 |->
      dst_o[DST_W-1:HALF_W] == '0); // R8
  AST_BAD_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(mode_i) == 2'd3 |-> fault_ud_o); // R9
  AST_MASKED_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && $past(inv_mask_i) |-> !fault_inv_o); // R2
endmodule

// File: tb/fp64_trunc_cvt_tb.sv
module fp64_trunc_cvt_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   mode_i = '0;
  logic [3:0]   rsvd_i = '0;
  logic         inv_mask_i = 1'b1;
  logic [255:0] src_i = '0;
  logic [255:0] old_dst_i = '0;
  logic         valid_o, inv_o, prec_o, fault_inv_o, fault_ud_o;
  logic [255:0] dst_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  fp64_trunc_cvt u_dut (
    .clk_i, .rst_ni, .valid_i, .mode_i, .rsvd_i, .inv_mask_i, .src_i, .old_dst_i,
    .valid_o, .dst_o, .inv_o, .prec_o, .fault_inv_o, .fault_ud_o
  );

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h exp %h", tag, act, exp);
    end
  endtask

  // reference: {inv, inx, val}
  function automatic logic [33:0] ref_lane(logic [63:0] b);
    real r;
    int  t;
    if (b[62:52] == 11'h7FF) return {2'b10, 32'h8000_0000};
    r = $bitstoreal(b);
    if (r >= 2147483648.0 || r <= -2147483649.0) return {2'b10, 32'h8000_0000};
    t = $rtoi(r);
    return {1'b0, ($itor(t) != r), t};
  endfunction

  task automatic run(string tag, logic [255:0] src, logic [255:0] old,
                     logic [1:0] mode, logic [3:0] rsvd, logic mask);
    logic [255:0] e_dst;
    logic [33:0]  l;
    logic e_inv, e_inx, e_ud, e_trap;
    int nl;
    e_ud  = (mode == 2'd3) || (mode != 2'd0 && rsvd != 4'hF);
    nl    = (mode == 2'd2) ? 4 : 2;
    e_inv = 0; e_inx = 0; e_dst = '0;
    for (int i = 0; i < nl; i++) begin
      l = ref_lane(src[64*i +: 64]);
      e_inv |= l[33];
      e_inx |= l[32];
      e_dst[32*i +: 32] = l[31:0];
    end
    if (mode == 2'd0) e_dst[255:128] = old[255:128];
    e_trap = !e_ud && e_inv && !mask;
    if (e_ud || e_trap) e_dst = old;
    if (e_ud) begin e_inv = 0; e_inx = 0; end
    @(negedge clk_i);
    src_i = src; old_dst_i = old; mode_i = mode; rsvd_i = rsvd; inv_mask_i = mask;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
    check({tag, " R11 valid"}, {255'b0, valid_o}, 256'd1);
    check({tag, " R1 R5 R6 R7 R8 dst"}, dst_o, e_dst);
    check({tag, " R2 R3 inv"}, {255'b0, inv_o}, {255'b0, e_inv});
    check({tag, " R4 prec"}, {255'b0, prec_o}, {255'b0, e_inx});
    check({tag, " R9 R10 faults"}, {254'b0, fault_ud_o, fault_inv_o}, {254'b0, e_ud, e_trap});
    @(negedge clk_i);
    check({tag, " R11 idle"}, {255'b0, valid_o}, 256'd0);
  endtask

  function automatic logic [63:0] rnd_lane();
    logic [63:0] b;
    b = {$urandom, $urandom};
    case ($urandom_range(0, 9))
      0: b[62:52] = 11'h7FF;
      1: b[62:52] = 11'h000;
      2: b[62:52] = 11'd1054;
      3: b[62:52] = 11'd1053;
      4: b[51:0]  = {12'b0, 40'b0} | (b[51:0] & 52'hFFFFF_00000000);
      default: b[62:52] = 11'($urandom_range(1013, 1060));
    endcase
    return b;
  endfunction

  function automatic logic [63:0] d(real v);
    return $realtobits(v);
  endfunction

  initial begin
    logic [255:0] old;
    logic [63:0]  nan, pinf, ninf;
    void'($urandom(32'd20240611));
    nan  = 64'h7FF8_0000_0000_0000;
    pinf = 64'h7FF0_0000_0000_0000;
    ninf = 64'hFFF0_0000_0000_0000;
    old  = {8{32'hA5A5_5A5A}};
    repeat (3) @(negedge clk_i);
    check("R11 reset", {dst_o[251:0], valid_o, inv_o, prec_o, fault_inv_o, fault_ud_o}[255:0],
          '0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run("R2 R3 bounds", {d(-2147483647.5), d(2147483647.5), d(-2147483648.0), d(2147483648.0)},
        old, 2'd2, 4'hF, 1'b1);
    run("R3 neg-trunc", {d(1.0), d(-2147483648.5), d(-2147483648.0), d(-2147483649.0)},
        old, 2'd2, 4'hF, 1'b1);
    run("R3 exact-min", {d(7.0), d(-2147483648.5), d(-2147483648.0), d(5.0)},
        old, 2'd2, 4'hF, 1'b1);
    run("R2 special", {d(1.5), ninf, pinf, nan}, old, 2'd2, 4'hF, 1'b1);
    run("R4 tiny", {d(-3.99), d(0.75), 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000},
        old, 2'd2, 4'hF, 1'b1);
    run("R4 zero-exact", {d(0.0), d(100.0), d(-7.0), 64'h8000_0000_0000_0000},
        old, 2'd2, 4'hF, 1'b1);
    run("R1 frac", {d(-123456.789), d(99.99), d(-0.999), d(2147483646.9)},
        old, 2'd2, 4'hF, 1'b1);
    run("R5 R6 merge-ign", {nan, d(0.5), d(-9.25), d(12.0)}, old, 2'd0, 4'h0, 1'b1);
    run("R7 zero2", {pinf, nan, d(-1.0), d(3.5)}, old, 2'd1, 4'hF, 1'b0);
    run("R10 trap", {d(1.0), d(2.0), nan, d(3.0)}, old, 2'd2, 4'hF, 1'b0);
    run("R10 trap2", {d(1.0), d(2.0), d(3.7), d(-4e12)}, old, 2'd1, 4'hF, 1'b0);
    run("R9 rsvd", {d(1.0), d(2.0), d(3.0), d(4.5)}, old, 2'd1, 4'h7, 1'b1);
    run("R9 rsvd4", {nan, d(2.0), d(3.0), d(4.5)}, old, 2'd2, 4'hE, 1'b0);
    run("R9 mode3", {d(1.0), d(2.0), d(3.0), d(4.5)}, old, 2'd3, 4'hF, 1'b1);

    for (int k = 0; k < 600; k++) begin
      logic [255:0] s;
      logic [1:0]   m;
      logic [3:0]   rv;
      for (int j = 0; j < 4; j++) s[64*j +: 64] = rnd_lane();
      for (int j = 0; j < 8; j++) old[32*j +: 32] = $urandom;
      m  = 2'($urandom_range(0, 3));
      rv = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
      run("R1 R2 R4 R5 rand", s, old, m, rv, ($urandom_range(0, 3) != 0));
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule